// File: doc/BRIEF.md
# Guarded Processor Status Word Register

This block holds the 16-bit processor status word of a minicomputer-style CPU and decides which bits of an incoming value may be taken. Two sources can load it: a direct write, which only kernel-mode code may perform, and the status restore done when a return from interrupt or from trap pops a saved word off the stack. Both of those return opcodes feed the same restore strobe.

On the restore path the popped word is filtered so that code cannot raise its own privilege:
- The mode fields can only move toward less privilege.
- Outside kernel mode the priority level is locked.
- Once the alternate register set is selected, it cannot be deselected.

Any candidate value whose current or previous mode would hold the undefined encoding is refused. When that happens the word stays as it was, and a reserved-instruction trap pulse is raised in the same cycle as the strobe.

The block presents the whole word and its decoded fields. The stack pop, the program-counter restore, the register-file switching and trace-trap generation all belong to the surrounding CPU.

Top module: `psw_guard`

## Requirements
- R1: A synchronous reset, active high, clears the whole status word to 0x0000: kernel mode, priority 0, with every flag clear.
- R2: The field positions are fixed:
  - current mode in bits 15:14;
  - previous mode in bits 13:12;
  - register-set select in bit 11;
  - priority in bits 7:5;
  - trace in bit 4;
  - N, Z, V and C in bits 3, 2, 1 and 0.
  
  Bits 10:8 always read as zero, whatever value is loaded.
- R3: When the current mode is kernel (encoding 0) and the write strobe is high, the next clock edge loads every defined field from the write data.
- R4: A direct write issued while the current mode is not kernel leaves the word unchanged and raises no trap.
- R5: Mode encodings are 0 for kernel, 1 for supervisor, 3 for user, and 2 for undefined. If the value that would be loaded has the undefined encoding in its current-mode or previous-mode field, the word is unchanged and the trap output is high in that same cycle. In every other case the trap output is low.
- R6: On a restore, each new mode field is the numerically larger of its present value and the popped value.
- R7: On a restore, the popped priority is loaded only when the present current mode is kernel. Otherwise the priority keeps its present value.
- R8: On a restore, the new register-set bit is the OR of the present bit and the popped bit.
- R9: On a restore, the trace bit and the four condition codes are taken from the popped word without restriction.
- R10: When the restore strobe and the write strobe are high in the same cycle, only the restore takes effect. The trap output then depends only on the restore candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Direct-write strobe, one cycle |
| wr_data | input | 16 | Value for a direct write |
| ret_en | input | 1 | Restore strobe from return-from-interrupt or return-from-trap, one cycle |
| pop_data | input | 16 | Status word popped from the stack |
| psw | output | 16 | Full status word |
| cur_mode | output | 2 | Current mode field |
| prev_mode | output | 2 | Previous mode field |
| reg_set | output | 1 | Register-set select |
| prio | output | 3 | Priority level |
| trace | output | 1 | Trace bit |
| cc | output | 4 | Condition codes N, Z, V, C (bit 3 down to bit 0) |
| rsvd_trap | output | 1 | Reserved-instruction trap pulse |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a restore and a direct write. The bench raises both strobes together with different data words and then checks two things: that the word holds the filtered restore value rather than the write data, and that a write word with an undefined mode does not raise the trap when the restore candidate is legal.

The second pair is the mode-maximum filter and the undefined-mode check. The bench pops a word whose mode is encoding 2. With the present mode at supervisor, the maximum is 2, so a trap must appear and the word must stay unchanged. With the present previous mode at user, the maximum stays 3, so the load goes ahead without a trap.

// File: rtl/psw_guard.sv
module psw_guard (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        ret_en,
  input  logic [15:0] pop_data,
  output logic [15:0] psw,
  output logic [1:0]  cur_mode,
  output logic [1:0]  prev_mode,
  output logic        reg_set,
  output logic [2:0]  prio,
  output logic        trace,
  output logic [3:0]  cc,
  output logic        rsvd_trap
);
  localparam logic [1:0] KERNEL = 2'd0;
  localparam logic [1:0] UNDEF  = 2'd2;

  logic [15:0] word_q;
  logic [15:0] cand;
  logic        take;
  logic        is_kernel;
  logic [1:0]  ret_cm, ret_pm;

  assign is_kernel = (word_q[15:14] == KERNEL);
  assign ret_cm = (pop_data[15:14] > word_q[15:14]) ? pop_data[15:14] : word_q[15:14];
  assign ret_pm = (pop_data[13:12] > word_q[13:12]) ? pop_data[13:12] : word_q[13:12];

  always_comb begin
    cand = word_q;
    take = 1'b0;
    if (ret_en) begin
      take = 1'b1;
      cand = {ret_cm, ret_pm, word_q[11] | pop_data[11], 3'b000,
              is_kernel ? pop_data[7:5] : word_q[7:5], pop_data[4:0]};
    end else if (wr_en && is_kernel) begin
      take = 1'b1;
      cand = {wr_data[15:11], 3'b000, wr_data[7:0]};
    end
  end

  assign rsvd_trap = take && (cand[15:14] == UNDEF || cand[13:12] == UNDEF);

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= 16'h0000;
    else if (take && !rsvd_trap)
      word_q <= cand;
  end

  assign psw       = word_q;
  assign cur_mode  = word_q[15:14];
  assign prev_mode = word_q[13:12];
  assign reg_set   = word_q[11];
  assign prio      = word_q[7:5];
  assign trace     = word_q[4];
  assign cc        = word_q[3:0];
endmodule

module psw_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        ret_en,
  input logic [15:0] psw,
  input logic        rsvd_trap
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> psw == 16'h0000);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst) psw[10:8] == 3'b000);
  assert_user_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ret_en && psw[15:14] != 2'd0) |=> $stable(psw));
  assert_trap_holds_word_R5: assert property (@(posedge clk) disable iff (rst)
    rsvd_trap |=> $stable(psw));
  assert_no_undef_mode_R5: assert property (@(posedge clk) disable iff (rst)
    psw[15:14] != 2'd2 && psw[13:12] != 2'd2);
  assert_trap_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    rsvd_trap |-> (wr_en || ret_en));
  assert_mode_no_lower_R6: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> (psw[15:14] >= $past(psw[15:14]) && psw[13:12] >= $past(psw[13:12])));
  assert_prio_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_en && psw[15:14] != 2'd0) |=> psw[7:5] == $past(psw[7:5]));
  assert_regset_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_en && psw[11]) |=> psw[11]);
endmodule

bind psw_guard psw_guard_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .ret_en(ret_en),
  .psw(psw), .rsvd_trap(rsvd_trap)
);

// File: tb/sim_psw_guard.sv
module sim_psw_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        ret_en = 1'b0;
  logic [15:0] pop_data = 16'h0;
  logic [15:0] psw;
  logic [1:0]  cur_mode, prev_mode;
  logic        reg_set, trace, rsvd_trap;
  logic [2:0]  prio;
  logic [3:0]  cc;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  psw_guard u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ret_en(ret_en), .pop_data(pop_data), .psw(psw),
    .cur_mode(cur_mode), .prev_mode(prev_mode), .reg_set(reg_set),
    .prio(prio), .trace(trace), .cc(cc), .rsvd_trap(rsvd_trap)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one strobe cycle; check trap mid-cycle and the word after the edge.
  task automatic step(input string req, input logic w, input logic [15:0] wd,
                      input logic r, input logic [15:0] pd,
                      input logic exp_trap, input logic [15:0] exp_psw);
    @(negedge clk);
    wr_en = w; wr_data = wd; ret_en = r; pop_data = pd;
    #1;
    check({req, " trap"}, {15'd0, rsvd_trap}, {15'd0, exp_trap});
    @(posedge clk); #1;
    wr_en = 1'b0; ret_en = 1'b0;
    check({req, " psw"}, psw, exp_psw);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset word", psw, 16'h0000);
    check("R1 reset trap", {15'd0, rsvd_trap}, 16'h0);
  endtask

  task automatic t_kernel_write();
    step("R3 kernel write", 1, 16'h3FBA, 0, 16'h0, 0, 16'h38BA);
    check("R2 prev_mode", {14'd0, prev_mode}, 16'd3);
    check("R2 reg_set", {15'd0, reg_set}, 16'd1);
    check("R2 prio", {13'd0, prio}, 16'd5);
    check("R2 trace", {15'd0, trace}, 16'd1);
    check("R2 cc", {12'd0, cc}, 16'hA);
    check("R2 cur_mode", {14'd0, cur_mode}, 16'd0);
  endtask

  task automatic t_undef_write();
    step("R5 undef cur on write", 1, 16'h8000, 0, 16'h0, 1, 16'h38BA);
    step("R5 undef prev on write", 1, 16'h2000, 0, 16'h0, 1, 16'h38BA);
    step("R5 R6 R8 pop prev 2 under user prev", 0, 16'h0, 1, 16'h2000, 0, 16'h3800);
  endtask

  task automatic t_restore_kernel();
    step("R7 R9 kernel restore", 0, 16'h0, 1, 16'h10F5, 0, 16'h38F5);
    step("R6 mode rises", 0, 16'h0, 1, 16'h4000, 0, 16'h7800);
    check("R6 cur_mode", {14'd0, cur_mode}, 16'd1);
  endtask

  task automatic t_user_write();
    step("R4 write outside kernel", 1, 16'h0000, 0, 16'h0, 0, 16'h7800);
  endtask

  task automatic t_restore_locked();
    step("R6 R7 R8 R9 locked restore", 0, 16'h0, 1, 16'h00EF, 0, 16'h780F);
    step("R5 undef via max on restore", 0, 16'h0, 1, 16'h8000, 1, 16'h780F);
  endtask

  task automatic t_both();
    do_reset();
    step("R10 both strobes", 1, 16'h0012, 1, 16'hC0E3, 0, 16'hC0E3);
    do_reset();
    step("R10 R2 both strobes undef write", 1, 16'h8000, 1, 16'h0704, 0, 16'h0004);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_kernel_write();
    t_undef_write();
    t_restore_kernel();
    t_user_write();
    t_restore_locked();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule